// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Finder

This block scans a stream of object-code bytes for a compact 8/16-bit microcontroller instruction set and finds where each instruction begins and ends. Bytes arrive one at a time on a valid/ready input. Each accepted byte leaves the block one cycle later on a registered output beat. The beat carries the byte, its own address, flags for the first and the final byte of its instruction, the number of bytes of that instruction seen so far, and the address where the instruction starts.

Most opcodes have a length that is fixed in a small internal table. Three cases need more than one byte of context. The byte $18 is a prefix that sends the next byte to a second opcode page. Indexed opcodes take one postbyte, and certain bit patterns in that postbyte ask for one or two more offset bytes. Every byte of the current instruction is used up before any byte is read as a new opcode, so operand bytes are never decoded as opcodes. An address counter can be loaded with a base address and then advances by one for each accepted byte. An opcode that is not in the table ends its instruction at once and raises an illegal flag.

Top module: `ilen_scanner`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the address counter is 0 and the next byte is decoded as an opcode.
- R2: While base_load is high, in_ready is low and the address counter takes base_addr. Each accepted byte then gets the next address, modulo 2^ADDR_W. out_start is the address of the instruction's first byte.
- R3: These page-one opcodes have fixed total lengths: $3F, $A7, $87, $C7, $08 and $09 are 1 byte; $C6, $86 and $B7 are 2 bytes; $FE, $F6, $CC, $CE and $04 are 3 bytes.
- R4: $18 is a prefix. If the following byte is $06, $16, $17, $0E or $0F, the instruction is 2 bytes in total, with the prefix counted.
- R5: The indexed opcodes are $A6, $E6, $60, $6A and $EE. If the postbyte does not match 111xx0xx (bits 7..5 set and bit 2 clear), the instruction is 2 bytes.
- R6: For an indexed opcode whose postbyte matches 111xx00x (bits 7..5 set, bits 2..1 equal to 00), the instruction is 3 bytes.
- R7: For an indexed opcode whose postbyte matches 111xx01x (bits 7..5 set, bits 2..1 equal to 01), the instruction is 4 bytes.
- R8: A page-one opcode that is not in R3, R4 or R5 is a 1-byte instruction. A page-two byte that is not in R4 makes a 2-byte instruction. In both cases out_illegal is high on the final byte, and it is never high on any other beat.
- R9: out_first is high only on an instruction's first byte and out_last only on its final byte. out_len counts the bytes of the instruction up to and including the current beat. A byte inside an instruction never starts a new one, whatever its value.
- R10: While out_valid is high and out_ready is low, in_ready is low and every output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_load | input | 1 | Load the address counter and restart decoding at an opcode |
| base_addr | input | ADDR_W | Address loaded by base_load |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Object-code byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 8 | The byte of this beat |
| out_addr | output | ADDR_W | Address of this byte |
| out_first | output | 1 | Byte is the first of its instruction |
| out_last | output | 1 | Byte is the final one of its instruction |
| out_len | output | 3 | Instruction bytes up to and including this one |
| out_start | output | ADDR_W | Address of the instruction's first byte |
| out_illegal | output | 1 | Instruction not in the table (final byte only) |

## Verification
The output register can drain a finished beat and capture a new byte in the same cycle. The same register also has to hold a stalled beat while the next byte waits at the input. The bench drives out_ready and in_valid from separate pseudo-random bits. This makes drain-and-capture cycles, stalled cycles and stalls that start while a byte is offered occur many times inside prefix, postbyte and tail sequences. Each beat that is taken is compared with a per-byte expectation computed from the requirements. In every stalled cycle the bench checks that the beat held from the previous cycle is unchanged and that in_ready is low.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam logic [BYTE_W-1:0] PAGE2_PREFIX = 8'h18;

  typedef enum logic [1:0] {
    KIND_FIXED,
    KIND_INDEXED,
    KIND_PREFIX,
    KIND_UNKNOWN
  } kind_e;

  typedef enum logic [1:0] {
    ST_OPC,
    ST_PG2,
    ST_POST,
    ST_TAIL
  } scan_st_e;

  typedef struct packed {
    kind_e             kind;
    logic [LEN_W-1:0]  len;
  } op_info_t;
endpackage

// File: rtl/ilen_optable.sv
module ilen_optable
  import ilen_pkg::*;
(
  input  logic              second_page,
  input  logic [BYTE_W-1:0] code,
  output op_info_t          info
);

  always_comb begin
    info.kind = KIND_UNKNOWN;
    info.len  = second_page ? LEN_W'(2) : LEN_W'(1);
    if (!second_page) begin
      case (code)
        8'h3F, 8'hA7, 8'h87, 8'hC7, 8'h08, 8'h09: begin
          info.kind = KIND_FIXED;
          info.len  = LEN_W'(1);
        end
        8'hC6, 8'h86, 8'hB7: begin
          info.kind = KIND_FIXED;
          info.len  = LEN_W'(2);
        end
        8'hFE, 8'hF6, 8'hCC, 8'hCE, 8'h04: begin
          info.kind = KIND_FIXED;
          info.len  = LEN_W'(3);
        end
        8'hA6, 8'hE6, 8'h60, 8'h6A, 8'hEE: begin
          info.kind = KIND_INDEXED;
          info.len  = LEN_W'(2);
        end
        PAGE2_PREFIX: begin
          info.kind = KIND_PREFIX;
          info.len  = LEN_W'(1);
        end
        default: ;
      endcase
    end else begin
      case (code)
        8'h06, 8'h16, 8'h17, 8'h0E, 8'h0F: begin
          info.kind = KIND_FIXED;
          info.len  = LEN_W'(2);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ilen_postbyte.sv
module ilen_postbyte (
  input  logic [2:0] top_bits,
  input  logic [1:0] mode_bits,
  output logic [1:0] extra
);

  localparam logic [2:0] WIDE_MARK = 3'b111;

  always_comb begin
    extra = 2'd0;
    if (top_bits == WIDE_MARK && !mode_bits[1]) begin
      extra = mode_bits[0] ? 2'd2 : 2'd1;
    end
  end

endmodule

// File: rtl/ilen_scanner.sv
module ilen_scanner
  import ilen_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_first,
  output logic              out_last,
  output logic [2:0]        out_len,
  output logic [ADDR_W-1:0] out_start,
  output logic              out_illegal
);

  localparam logic [LEN_W-1:0]  ONE   = LEN_W'(1);
  localparam logic [LEN_W-1:0]  TWO   = LEN_W'(2);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1);

  scan_st_e          st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] start_q, start_d;

  logic              ov_q;
  logic [7:0]        od_q;
  logic [ADDR_W-1:0] oa_q, os_q;
  logic              of_q, ol_q, oill_q;
  logic [LEN_W-1:0]  olen_q;

  op_info_t          info;
  logic [1:0]        extra;
  logic              take, drain;
  logic              is_first, is_last, is_ill;
  logic [LEN_W-1:0]  run_len;

  assign in_ready = ~base_load & (~ov_q | out_ready);
  assign take     = in_valid & in_ready;
  assign drain    = ov_q & out_ready;

  ilen_optable u_table (
    .second_page (st_q == ST_PG2),
    .code        (in_data),
    .info        (info)
  );

  ilen_postbyte u_postbyte (
    .top_bits  (in_data[7:5]),
    .mode_bits (in_data[2:1]),
    .extra     (extra)
  );

  // next-state decode for the byte being offered
  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    is_last  = 1'b0;
    is_ill   = 1'b0;
    is_first = (st_q == ST_OPC);
    run_len  = cnt_q + ONE;
    start_d  = is_first ? addr_q : start_q;
    unique case (st_q)
      ST_OPC: begin
        unique case (info.kind)
          KIND_FIXED: begin
            if (info.len == ONE) begin
              is_last = 1'b1;
            end else begin
              st_d  = ST_TAIL;
              rem_d = info.len - ONE;
            end
          end
          KIND_INDEXED: st_d = ST_POST;
          KIND_PREFIX:  st_d = ST_PG2;
          default: begin
            is_last = 1'b1;
            is_ill  = 1'b1;
          end
        endcase
      end
      ST_PG2: begin
        if (info.kind == KIND_FIXED) begin
          if (info.len == TWO) begin
            is_last = 1'b1;
          end else begin
            st_d  = ST_TAIL;
            rem_d = info.len - TWO;
          end
        end else begin
          is_last = 1'b1;
          is_ill  = 1'b1;
        end
      end
      ST_POST: begin
        if (extra == 2'd0) begin
          is_last = 1'b1;
        end else begin
          st_d  = ST_TAIL;
          rem_d = LEN_W'(extra);
        end
      end
      default: begin
        if (rem_q == ONE) begin
          is_last = 1'b1;
        end else begin
          rem_d = rem_q - ONE;
        end
      end
    endcase
    if (is_last) begin
      st_d = ST_OPC;
    end
    cnt_d = is_last ? '0 : run_len;
  end

  // scan state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OPC;
      cnt_q   <= '0;
      rem_q   <= '0;
      addr_q  <= '0;
      start_q <= '0;
    end else if (base_load) begin
      st_q    <= ST_OPC;
      cnt_q   <= '0;
      addr_q  <= base_addr;
    end else if (take) begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      addr_q  <= addr_q + STEP;
      start_q <= start_d;
    end
  end

  // output beat register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
    end else if (take) begin
      ov_q <= 1'b1;
    end else if (drain) begin
      ov_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q   <= '0;
      oa_q   <= '0;
      os_q   <= '0;
      of_q   <= 1'b0;
      ol_q   <= 1'b0;
      oill_q <= 1'b0;
      olen_q <= '0;
    end else if (take) begin
      od_q   <= in_data;
      oa_q   <= addr_q;
      os_q   <= start_d;
      of_q   <= is_first;
      ol_q   <= is_last;
      oill_q <= is_ill;
      olen_q <= run_len;
    end
  end

  assign out_valid   = ov_q;
  assign out_data    = od_q;
  assign out_addr    = oa_q;
  assign out_start   = os_q;
  assign out_first   = of_q;
  assign out_last    = ol_q;
  assign out_illegal = oill_q;
  assign out_len     = olen_q;

endmodule

// File: rtl/ilen_scanner_chk.sv
module ilen_scanner_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_first,
  input logic              out_last,
  input logic [2:0]        out_len,
  input logic [ADDR_W-1:0] out_start,
  input logic              out_illegal
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)
      && $stable(out_first) && $stable(out_last) && $stable(out_len))); // R10

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_len >= 3'd1 && out_len <= 3'd4)); // R9

  AST_FIRST_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == (out_len == 3'd1))); // R9

  AST_ADDR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr == out_start + ADDR_W'(out_len) - ADDR_W'(1))); // R2

  AST_ILLEGAL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_last && out_len <= 3'd2)); // R8

endmodule

bind ilen_scanner ilen_scanner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_addr    (out_addr),
  .out_first   (out_first),
  .out_last    (out_last),
  .out_len     (out_len),
  .out_start   (out_start),
  .out_illegal (out_illegal)
);

// File: tb/test_ilen_scanner.sv
module test_ilen_scanner;

  logic        clk;
  logic        rst_n;
  logic        base_load;
  logic [15:0] base_addr;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic [15:0] out_addr;
  logic        out_first;
  logic        out_last;
  logic [2:0]  out_len;
  logic [15:0] out_start;
  logic        out_illegal;

  ilen_scanner #(.ADDR_W(16)) i_ilen_scanner (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_load   (base_load),
    .base_addr   (base_addr),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_addr    (out_addr),
    .out_first   (out_first),
    .out_last    (out_last),
    .out_len     (out_len),
    .out_start   (out_start),
    .out_illegal (out_illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    timeout = 1'b0;

  logic [7:0]  s_byte  [0:4095];
  logic [15:0] s_addr  [0:4095];
  logic [15:0] s_start [0:4095];
  logic [2:0]  s_len   [0:4095];
  bit          s_first [0:4095];
  bit          s_last  [0:4095];
  bit          s_ill   [0:4095];
  string       s_tag   [0:4095];
  int          nb = 0;
  logic [15:0] cur_addr;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_fixed(input logic [7:0] op);
    case (op)
      8'h3F, 8'hA7, 8'h87, 8'hC7, 8'h08, 8'h09: return 1;
      8'hC6, 8'h86, 8'hB7:                      return 2;
      8'hFE, 8'hF6, 8'hCC, 8'hCE, 8'h04:        return 3;
      default:                                  return 0;
    endcase
  endfunction

  function automatic bit ref_indexed(input logic [7:0] op);
    return op inside {8'hA6, 8'hE6, 8'h60, 8'h6A, 8'hEE};
  endfunction

  function automatic bit ref_page2(input logic [7:0] op);
    return op inside {8'h06, 8'h16, 8'h17, 8'h0E, 8'h0F};
  endfunction

  task automatic put_instr(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3,
                           input int n, input bit ill, input string tag);
    logic [15:0] st;
    st = cur_addr;
    for (int k = 0; k < n; k++) begin
      case (k)
        0:       s_byte[nb] = b0;
        1:       s_byte[nb] = b1;
        2:       s_byte[nb] = b2;
        default: s_byte[nb] = b3;
      endcase
      s_addr[nb]  = cur_addr;
      s_start[nb] = st;
      s_len[nb]   = 3'(k + 1);
      s_first[nb] = (k == 0);
      s_last[nb]  = (k == n - 1);
      s_ill[nb]   = ill && (k == n - 1);
      s_tag[nb]   = tag;
      nb++;
      cur_addr = cur_addr + 16'd1;
    end
  endtask

  // filler bytes are the prefix value: a decoder that restarts inside an
  // instruction would misread them (R9)
  task automatic put_from(input logic [7:0] op, input logic [7:0] p);
    localparam logic [7:0] F = 8'h18;
    int n;
    n = ref_fixed(op);
    if (n != 0) begin
      put_instr(op, F, F, F, n, 1'b0, "R3");
    end else if (op == 8'h18) begin
      if (ref_page2(p)) put_instr(op, p, F, F, 2, 1'b0, "R4");
      else              put_instr(op, p, F, F, 2, 1'b1, "R8");
    end else if (ref_indexed(op)) begin
      if (p[7:5] == 3'b111 && !p[2]) begin
        if (p[1]) put_instr(op, p, F, F, 4, 1'b0, "R7");
        else      put_instr(op, p, F, F, 3, 1'b0, "R6");
      end else begin
        put_instr(op, p, F, F, 2, 1'b0, "R5");
      end
    end else begin
      put_instr(op, F, F, F, 1, 1'b1, "R8");
    end
  endtask

  task automatic run_seg(input int lo, input int hi, input logic [15:0] base,
                         input bit do_load);
    int ii, oi;
    bit stalled, rdy;
    logic [7:0]  sv_d;
    logic [15:0] sv_a;
    logic [2:0]  sv_l;
    bit          sv_f, sv_z;
    if (timeout) return;
    if (do_load) begin
      @(negedge clk);
      base_load = 1'b1;
      base_addr = base;
      in_valid  = 1'b0;
      #1;
      chk(in_ready == 1'b0, "R2", "in_ready during load", in_ready, 0);
      @(negedge clk);
      base_load = 1'b0;
    end
    ii = lo;
    oi = lo;
    stalled = 1'b0;
    while (oi < hi && !timeout) begin
      rdy = lf[0] | lf[3];
      if (stalled) begin
        chk(out_valid && out_data == sv_d && out_addr == sv_a && out_len == sv_l
            && out_first == sv_f && out_last == sv_z, "R10", "held beat",
            {out_data, out_addr}, {sv_d, sv_a});
      end
      out_ready = rdy;
      if (out_valid && rdy) begin
        chk(out_data == s_byte[oi], "R9", "data", out_data, s_byte[oi]);
        chk(out_addr == s_addr[oi], "R2", "addr", out_addr, s_addr[oi]);
        chk(out_start == s_start[oi], "R2", "start", out_start, s_start[oi]);
        chk(out_first == s_first[oi] && out_last == s_last[oi], "R9", "first/last",
            {out_first, out_last}, {s_first[oi], s_last[oi]});
        chk(out_len == s_len[oi], s_tag[oi], "len", out_len, s_len[oi]);
        chk(out_illegal == s_ill[oi], "R8", "illegal", out_illegal, s_ill[oi]);
        oi++;
      end
      stalled = out_valid && !rdy;
      sv_d = out_data;
      sv_a = out_addr;
      sv_l = out_len;
      sv_f = out_first;
      sv_z = out_last;
      in_valid = (ii < hi) && (lf[5] | lf[1]);
      in_data  = (ii < hi) ? s_byte[ii] : 8'h00;
      #1;
      if (out_valid && !rdy) begin
        chk(in_ready == 1'b0, "R10", "in_ready while stalled", in_ready, 0);
      end
      if (in_valid && in_ready) ii++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    timeout = 1'b1;
  end

  initial begin
    int lo;
    rst_n = 1'b0;
    base_load = 1'b0;
    base_addr = '0;
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // mixed sequence at the reset address
    cur_addr = 16'h0000;
    lo = nb;
    put_from(8'hC6, 8'h00);
    put_from(8'hFE, 8'h00);
    put_from(8'hE6, 8'h01);
    put_from(8'h18, 8'h06);
    put_from(8'hB7, 8'h00);
    put_from(8'h04, 8'h00);
    put_from(8'h3F, 8'h00);
    run_seg(lo, nb, 16'h0000, 1'b0);

    // every page-one opcode
    cur_addr = 16'h4000;
    lo = nb;
    for (int op = 0; op < 256; op++) put_from(8'(op), 8'h06);
    run_seg(lo, nb, 16'h4000, 1'b1);

    // every page-two byte after the prefix
    cur_addr = 16'h8100;
    lo = nb;
    for (int x = 0; x < 256; x++) put_from(8'h18, 8'(x));
    run_seg(lo, nb, 16'h8100, 1'b1);

    // every postbyte on indexed opcodes
    cur_addr = 16'hC000;
    lo = nb;
    for (int p = 0; p < 256; p++) begin
      case (p % 3)
        0:       put_from(8'hE6, 8'(p));
        1:       put_from(8'hA6, 8'(p));
        default: put_from(8'h6A, 8'(p));
      endcase
    end
    run_seg(lo, nb, 16'hC000, 1'b1);

    // address wrap across an instruction
    cur_addr = 16'hFFFD;
    lo = nb;
    put_from(8'hC6, 8'h00);
    put_from(8'hFE, 8'h00);
    put_from(8'hEE, 8'hE2);
    run_seg(lo, nb, 16'hFFFD, 1'b1);

    if (timeout) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule